// File: doc/BRIEF.md
# SDRAM Command-Issue Hazard Scheduler

This block sits between a request queue and the command bus of one or more SDRAM ranks. It takes one read or write request at a time, each naming a rank, a bank, a row and a column. For each request it opens the row with an activate command when needed and then issues the read or write column command. Row and column addresses share one set of address wires, and every command holds those wires for two consecutive cycles. While doing this the scheduler enforces the spacing rules of the memory. These are the turnaround bubble on the data bus between reads and writes, the one-cycle gap between reads served by different ranks, and the minimum interval before a bank may open a different row.

The scheduler keeps one open-row entry for every bank of every rank, so a request to the row that is already open skips the activate. It also keeps a short schedule of future data-bus cycles. From that schedule it reports, cycle by cycle, when a burst is expected on the data bus, whether that burst is a write, and which rank it belongs to. Requests are served strictly in arrival order.

The control state machine has five states. IDLE waits for a request; accepting one moves to ROW. ROW goes to COL if the row is already open. Otherwise, once the bank's row-conflict timer has expired, ROW issues the activate and moves to ACT2. ACT2 is the second address cycle of the activate and always moves to COL. COL waits until the data-bus spacing allows the column command, issues it, and moves to COL2. COL2 is the second address cycle of the column command. It returns to IDLE, or goes straight to ROW if a new request is accepted in that cycle.

Top module: `sdram_hazard_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, req_ready is 1, cmd_op is 0 (no command), cmd_first is 0 and dq_active is 0.
- R2: Every command drives cmd_op, cmd_rank, cmd_bank and cmd_addr unchanged for two consecutive cycles. cmd_first is 1 in the first of those cycles and 0 in the second, and no other command starts in the second cycle. The codes for cmd_op are 0 for no command, 1 for activate, 2 for read and 3 for write.
- R3: A request whose bank has no open row, or has a different row open, produces an activate carrying the row on cmd_addr, followed by the column command carrying the column. A request to the open row produces only the column command.
- R4: dq_active is 1 for exactly BURST_LEN (default 4) consecutive cycles for each column command. The window starts RD_OFS (default 3) cycles after the first cycle of a read command, or WR_OFS (default 1) cycles after the first cycle of a write command. Two windows never overlap.
- R5: When a burst's direction differs from the burst before it, at least one cycle with dq_active at 0 separates them.
- R6: Two consecutive read bursts to different ranks are separated by at least one cycle with dq_active at 0. Consecutive bursts of the same direction to the same rank may be back to back.
- R7: An activate to a bank starts no earlier than ROW_GAP (default 7) cycles after the first cycle of the previous command to that same bank and rank.
- R8: Only one request is in service at a time, and commands follow the arrival order of requests. req_ready is 1 only in IDLE and in the second cycle of a column command, and it is 0 in the cycle after a request is accepted.
- R9: Open rows are tracked separately for each bank of each rank (4 banks per rank by default). Opening a row in one rank leaves the open row of the same bank number in another rank intact.
- R10: While dq_active is 1, dq_write is 1 for a write burst and 0 for a read burst, and dq_rank gives the rank of that burst's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Scheduler can take a request this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_rank | input | RK_W | Target rank |
| req_bank | input | BK_W | Target bank within the rank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd_op | output | 2 | Command on the bus: 0 none, 1 activate, 2 read, 3 write |
| cmd_first | output | 1 | First of the two address cycles of a command |
| cmd_rank | output | RK_W | Rank of the command |
| cmd_bank | output | BK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row (activate) or column (read/write) address |
| dq_active | output | 1 | A data burst is expected on the data bus this cycle |
| dq_write | output | 1 | The expected burst is a write |
| dq_rank | output | RK_W | Rank of the expected burst |

## Verification
A command appears on the bus at the earliest in the cycle after its request is accepted. Its second address cycle follows one cycle later, and the data window opens 3 cycles (read) or 1 cycle (write) after the command's first cycle. An activate may start no earlier than 7 cycles after the previous command to the same bank. The bench samples every output on the falling edge and numbers cycles with its own counter. Each command is matched against a queue of expected commands filled by the driver, and the monitor turns each column command into an expected burst start at its own cycle plus the direction's offset. The monitor then checks that window cycle by cycle and measures the idle cycles between bursts against the bubble each pair of bursts needs.

// File: rtl/sdsch_pkg.sv
package sdsch_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ROW  = 3'd1,
        S_ACT2 = 3'd2,
        S_COL  = 3'd3,
        S_COL2 = 3'd4
    } sched_state_e;

endpackage

// File: rtl/sdsch_bank_table.sv
module sdsch_bank_table #(
    parameter int NENT    = 8,
    parameter int IDX_W   = 3,
    parameter int ROW_W   = 13,
    parameter int ROW_GAP = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             col_fire,
    input  logic [IDX_W-1:0] sel,
    input  logic [ROW_W-1:0] row_in,
    output logic             hit,
    output logic             tmr_zero
);
    localparam int TW = $clog2(ROW_GAP + 1);
    localparam logic [TW-1:0] RELOAD = TW'(ROW_GAP - 1);

    logic             open_v   [NENT];
    logic [ROW_W-1:0] open_row [NENT];
    logic [TW-1:0]    tmr      [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_v[g]   <= 1'b0;
                open_row[g] <= '0;
                tmr[g]      <= '0;
            end else begin
                if (act_fire && (int'(sel) == g)) begin
                    open_v[g]   <= 1'b1;
                    open_row[g] <= row_in;
                end
                if ((act_fire || col_fire) && (int'(sel) == g)) begin
                    tmr[g] <= RELOAD;
                end else if (tmr[g] != '0) begin
                    tmr[g] <= tmr[g] - 1'b1;
                end
            end
        end
    end

    always_comb begin
        hit      = open_v[sel] && (open_row[sel] == row_in);
        tmr_zero = (tmr[sel] == '0);
    end

    AST_NO_HIT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !(open_v[sel] && (open_row[sel] == row_in))); // R3

    AST_ROW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> (tmr[sel] == '0)); // R7

endmodule

// File: rtl/sdsch_dbus.sv
module sdsch_dbus #(
    parameter int RK_W   = 1,
    parameter int RD_OFS = 3,
    parameter int WR_OFS = 1,
    parameter int BURST  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            is_wr,
    input  logic [RK_W-1:0] rank,
    output logic            gap_ok,
    output logic            dq_active,
    output logic            dq_write,
    output logic [RK_W-1:0] dq_rank
);
    localparam int MAXOFS = (RD_OFS > WR_OFS) ? RD_OFS : WR_OFS;
    localparam int W      = MAXOFS + BURST - 1;
    localparam int FW     = $clog2(W + 1);

    logic            busy     [W];
    logic            sched_wr [W];
    logic [RK_W-1:0] sched_rk [W];
    logic [W-1:0]    busy_vec;
    logic [W-1:0]    new_mask;
    logic [FW-1:0]   free_in;
    logic            last_wr;
    logic [RK_W-1:0] last_rk;
    logic            need_gap;
    int              ofs;

    always_comb begin
        ofs      = is_wr ? WR_OFS : RD_OFS;
        need_gap = (last_wr != is_wr) || (!is_wr && (last_rk != rank));
        gap_ok   = ofs >= (int'(free_in) + int'(need_gap));
        for (int j = 0; j < W; j++) begin
            new_mask[j] = (j >= ofs - 1) && (j < ofs - 1 + BURST);
            busy_vec[j] = busy[j];
        end
    end

    for (genvar j = 0; j < W; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[j]     <= 1'b0;
                sched_wr[j] <= 1'b0;
                sched_rk[j] <= '0;
            end else if (issue && new_mask[j]) begin
                busy[j]     <= 1'b1;
                sched_wr[j] <= is_wr;
                sched_rk[j] <= rank;
            end else if (j < W - 1) begin
                busy[j]     <= busy[(j < W - 1) ? j + 1 : j];
                sched_wr[j] <= sched_wr[(j < W - 1) ? j + 1 : j];
                sched_rk[j] <= sched_rk[(j < W - 1) ? j + 1 : j];
            end else begin
                busy[j]     <= 1'b0;
                sched_wr[j] <= 1'b0;
                sched_rk[j] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_in <= '0;
            last_wr <= 1'b0;
            last_rk <= '0;
        end else if (issue) begin
            free_in <= FW'(ofs + BURST - 1);
            last_wr <= is_wr;
            last_rk <= rank;
        end else if (free_in != '0) begin
            free_in <= free_in - 1'b1;
        end
    end

    always_comb begin
        dq_active = busy[0];
        dq_write  = sched_wr[0];
        dq_rank   = sched_rk[0];
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (((busy_vec >> 1) & new_mask) == '0)); // R4

    AST_TURN_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_active && $past(dq_active)) |-> (dq_write == $past(dq_write))); // R5

    AST_RANK_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_active && $past(dq_active) && !dq_write) |-> (dq_rank == $past(dq_rank))); // R6

endmodule

// File: rtl/sdram_hazard_sched.sv
module sdram_hazard_sched
    import sdsch_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int ROW_GAP   = 7,
    parameter int RD_OFS    = 3,
    parameter int WR_OFS    = 1,
    parameter int BURST_LEN = 4,
    localparam int RK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [RK_W-1:0]   req_rank,
    input  logic [BK_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [1:0]        cmd_op,
    output logic              cmd_first,
    output logic [RK_W-1:0]   cmd_rank,
    output logic [BK_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              dq_active,
    output logic              dq_write,
    output logic [RK_W-1:0]   dq_rank
);
    localparam int NENT  = NUM_RANKS * NUM_BANKS;
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;

    sched_state_e state, state_nx;

    logic             r_write;
    logic [RK_W-1:0]  r_rank;
    logic [BK_W-1:0]  r_bank;
    logic [ROW_W-1:0] r_row;
    logic [COL_W-1:0] r_col;
    logic [IDX_W-1:0] sel;
    logic             take;
    logic             row_hit;
    logic             tmr_zero;
    logic             gap_ok;
    logic             act_go;
    logic             col_go;
    cmd_op_e          op_c;

    always_comb begin
        sel    = IDX_W'(int'(r_rank) * NUM_BANKS + int'(r_bank));
        take   = req_valid && req_ready;
        act_go = (state == S_ROW) && !row_hit && tmr_zero;
        col_go = (state == S_COL) && gap_ok;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_rank  <= '0;
            r_bank  <= '0;
            r_row   <= '0;
            r_col   <= '0;
        end else if (take) begin
            r_write <= req_write;
            r_rank  <= req_rank;
            r_bank  <= req_bank;
            r_row   <= req_row;
            r_col   <= req_col;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (take) state_nx = S_ROW;
            S_ROW: begin
                if (row_hit)       state_nx = S_COL;
                else if (tmr_zero) state_nx = S_ACT2;
            end
            S_ACT2: state_nx = S_COL;
            S_COL:  if (gap_ok) state_nx = S_COL2;
            S_COL2: state_nx = take ? S_ROW : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op_c      = OP_NOP;
        cmd_first = 1'b0;
        cmd_addr  = '0;
        req_ready = 1'b0;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_ROW: begin
                if (act_go) begin
                    op_c      = OP_ACT;
                    cmd_first = 1'b1;
                    cmd_addr  = ADDR_W'(r_row);
                end
            end
            S_ACT2: begin
                op_c     = OP_ACT;
                cmd_addr = ADDR_W'(r_row);
            end
            S_COL: begin
                if (col_go) begin
                    op_c      = r_write ? OP_WR : OP_RD;
                    cmd_first = 1'b1;
                    cmd_addr  = ADDR_W'(r_col);
                end
            end
            S_COL2: begin
                op_c      = r_write ? OP_WR : OP_RD;
                cmd_addr  = ADDR_W'(r_col);
                req_ready = 1'b1;
            end
            default: ;
        endcase
        cmd_op   = op_c;
        cmd_rank = r_rank;
        cmd_bank = r_bank;
    end

    sdsch_bank_table #(
        .NENT    (NENT),
        .IDX_W   (IDX_W),
        .ROW_W   (ROW_W),
        .ROW_GAP (ROW_GAP)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_go),
        .col_fire (col_go),
        .sel      (sel),
        .row_in   (r_row),
        .hit      (row_hit),
        .tmr_zero (tmr_zero)
    );

    sdsch_dbus #(
        .RK_W   (RK_W),
        .RD_OFS (RD_OFS),
        .WR_OFS (WR_OFS),
        .BURST  (BURST_LEN)
    ) u_dbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (col_go),
        .is_wr     (r_write),
        .rank      (r_rank),
        .gap_ok    (gap_ok),
        .dq_active (dq_active),
        .dq_write  (dq_write),
        .dq_rank   (dq_rank)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_first |=> (!cmd_first && cmd_op == $past(cmd_op) && cmd_addr == $past(cmd_addr))); // R2

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_FIRST_HAS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_first |-> (cmd_op != 2'd0)); // R2

endmodule

// File: tb/sdram_hazard_sched_bench.sv
module sdram_hazard_sched_bench;
    localparam int RD_OFS = 3;
    localparam int WR_OFS = 1;
    localparam int BLEN   = 4;
    localparam int RGAP   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_rank = '0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [1:0]  cmd_op;
    logic        cmd_first;
    logic [0:0]  cmd_rank;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        dq_active;
    logic        dq_write;
    logic [0:0]  dq_rank;

    sdram_hazard_sched u_sdram_hazard_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .cmd_op(cmd_op), .cmd_first(cmd_first),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .dq_active(dq_active), .dq_write(dq_write), .dq_rank(dq_rank)
    );

    always #2.5 clk = ~clk;

    typedef struct {int op; int rank; int bank; int addr; string tag;} cmd_t;
    typedef struct {int start; int wr; int rank;} burst_t;

    cmd_t   cmd_q[$];
    burst_t bq[$];
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    bit mon_on = 0;
    bit ov[8];
    int orow[8];
    int last_use[8];
    bit prev_first = 0;
    int prev_op = 0;
    int prev_addr = 0;
    bit have_last = 0;
    int last_end = 0;
    int last_wr = 0;
    int last_rk = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send(input bit wr, input int rk, input int bk, input int row,
                        input int col, input string tag);
        cmd_t c;
        int key;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_rank  = rk[0:0];
        req_bank  = bk[1:0];
        req_row   = row[12:0];
        req_col   = col[9:0];
        key = rk * 4 + bk;
        if (!(ov[key] && orow[key] == row)) begin
            c = '{op: 1, rank: rk, bank: bk, addr: row, tag: "R3"};
            cmd_q.push_back(c);
        end
        ov[key] = 1;
        orow[key] = row;
        c = '{op: wr ? 3 : 2, rank: rk, bank: bk, addr: col, tag: tag};
        cmd_q.push_back(c);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready after accept", int'(req_ready), 0);
    endtask

    // monitor: commands and data windows
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_first) begin
                chk(!cmd_first && int'(cmd_op) == prev_op && int'(cmd_addr) == prev_addr,
                    "R2 second address cycle", int'(cmd_op), prev_op);
            end
            if (cmd_first) begin
                if (cmd_q.size() == 0) begin
                    chk(0, "R8 unexpected command", int'(cmd_op), 0);
                end else begin
                    cmd_t e;
                    int key;
                    e = cmd_q.pop_front();
                    chk(int'(cmd_op) == e.op, {e.tag, " op"}, int'(cmd_op), e.op);
                    chk(int'(cmd_addr) == e.addr && int'(cmd_rank) == e.rank &&
                        int'(cmd_bank) == e.bank, {e.tag, " address"}, int'(cmd_addr), e.addr);
                    key = int'(cmd_rank) * 4 + int'(cmd_bank);
                    if (cmd_op == 2'd1 && last_use[key] >= 0)
                        chk(cyc - last_use[key] >= RGAP, "R7 row conflict gap",
                            cyc - last_use[key], RGAP);
                    last_use[key] = cyc;
                    if (cmd_op == 2'd2 || cmd_op == 2'd3) begin
                        burst_t b;
                        b.start = cyc + ((cmd_op == 2'd3) ? WR_OFS : RD_OFS);
                        b.wr    = (cmd_op == 2'd3) ? 1 : 0;
                        b.rank  = int'(cmd_rank);
                        bq.push_back(b);
                    end
                end
            end
            prev_first = cmd_first;
            prev_op    = int'(cmd_op);
            prev_addr  = int'(cmd_addr);

            if (bq.size() > 0 && bq[0].start == cyc) begin
                burst_t b;
                b = bq.pop_front();
                chk(dq_active, "R4 burst start", int'(dq_active), 1);
                chk(int'(dq_write) == b.wr, "R10 burst direction", int'(dq_write), b.wr);
                chk(int'(dq_rank) == b.rank, "R10 burst rank", int'(dq_rank), b.rank);
                if (have_last) begin
                    if (b.wr != last_wr)
                        chk(cyc - last_end >= 2, "R5 turnaround bubble", cyc - last_end - 1, 1);
                    else if (b.wr == 0 && b.rank != last_rk)
                        chk(cyc - last_end >= 2, "R6 rank switch bubble", cyc - last_end - 1, 1);
                    else
                        chk(cyc - last_end >= 1, "R4 no overlap", cyc - last_end - 1, 0);
                end
                have_last = 1;
                last_end  = cyc + BLEN - 1;
                last_wr   = b.wr;
                last_rk   = b.rank;
            end
            if (have_last && cyc <= last_end) begin
                chk(dq_active, "R4 burst length", int'(dq_active), 1);
            end else if (dq_active) begin
                chk(0, "R4 stray data cycle", int'(dq_active), 0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            ov[i] = 0;
            orow[i] = 0;
            last_use[i] = -1;
        end
        repeat (4) @(negedge clk);
        chk(req_ready && cmd_op == 2'd0 && !cmd_first && !dq_active,
            "R1 state during reset", int'(cmd_op), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && cmd_op == 2'd0 && !cmd_first && !dq_active,
            "R1 state after reset", int'(req_ready), 1);
        mon_on = 1;

        send(0, 0, 0, 10, 4,  "R3 read miss");
        send(0, 0, 0, 10, 8,  "R3 read hit back to back");
        send(1, 0, 0, 10, 12, "R5 write after read");
        send(0, 0, 1, 3, 16,  "R5 read after write");
        send(0, 1, 1, 7, 20,  "R6 read other rank");
        send(0, 0, 1, 3, 24,  "R9 hit kept across ranks");
        send(0, 0, 2, 1, 28,  "R3 read bank2");
        send(0, 0, 2, 2, 32,  "R7 same bank new row");
        send(1, 0, 2, 2, 36,  "R5 write hit");
        send(1, 0, 2, 2, 40,  "R4 write write");
        send(1, 1, 3, 100, 44, "R10 write rank1");
        send(0, 1, 3, 100, 48, "R5 read after write rank1");
        send(0, 0, 0, 11, 52, "R7 conflict bank0");

        repeat (40) @(negedge clk);
        chk(cmd_q.size() == 0, "R8 all commands issued", cmd_q.size(), 0);
        chk(bq.size() == 0, "R4 all bursts seen", bq.size(), 0);
        chk(req_ready && !dq_active, "R8 idle at end", int'(req_ready), 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule